// File: doc/BRIEF.md
# Shared-Line Memory Read/Write Target

This block is a memory target on a synchronous bus whose 32 data lines are time-shared. The same lines carry an address in one cycle and data in later cycles. An initiator starts a transaction by marking one cycle as an address cycle, with a read or write command and the byte address on the lines. For a read, the target spends a fixed access delay fetching a 64-bit word from its internal storage. It then takes ownership of the lines for two consecutive cycles and returns the low half first and the high half second. A read therefore occupies eight bus cycles from address to last beat.

For a write, the initiator follows the address cycle with two data cycles, low half first. Idle cycles may separate these beats. The target commits the full word after the second beat and never drives the lines. While a transaction is in flight the target reports busy, and it ignores any other bus traffic. The storage is a small array of 64-bit words that clears on reset. A word is selected by the address bits just above the byte offset of a 64-bit word.

Top module: `mbus_mem_target`

## Requirements
- R1: After reset `busy_o` and `drive_en_o` are 0, `bus_lines_o` is all zeros, and every stored word reads back as zero.
- R2: The phase encoding is 2'b00 idle, 2'b01 address and 2'b10 data. An address cycle is accepted only while `busy_o` is 0. `busy_o` is 1 from the cycle after acceptance until the transaction completes.
- R3: For a read (command 0), counting the address cycle as cycle 0, `drive_en_o` is 1 in exactly cycles ACCESS_LAT+1 and ACCESS_LAT+2 (6 and 7 by default) and 0 in every other cycle. `busy_o` returns to 0 in cycle ACCESS_LAT+3 (8), which may itself be the next address cycle.
- R4: The first reply beat carries bits 31:0 of the addressed word and the second beat carries bits 63:32.
- R5: `bus_lines_o` is all zeros whenever `drive_en_o` is 0, and `drive_en_o` is never 1 while `busy_o` is 0.
- R6: For a write (command 1), the first data cycle after the address supplies bits 31:0 and the second supplies bits 63:32. The word is stored after the second beat, `drive_en_o` stays 0 for the whole write, and `busy_o` is 0 in the cycle after the second beat.
- R7: During a write, cycles whose phase is not data do not count as beats, so the word is assembled from the next two data cycles, however many cycles separate them.
- R8: Address or data cycles that arrive while the target is busy have no effect. They change neither the word being returned nor the stored contents.
- R9: The word index is taken from address bits [3 +: IDX_W] (bits 6:3 for 16 words). Bits 2:0 and the bits above the index do not affect which word is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_phase_i | input | 2 | Cycle type: 00 idle, 01 address, 10 data |
| bus_cmd_i | input | 1 | Command in an address cycle: 0 read, 1 write |
| bus_lines_i | input | 32 | Shared lines as seen by the target (address or write data) |
| bus_lines_o | output | 32 | Read data the target places on the shared lines |
| drive_en_o | output | 1 | Target owns the shared lines this cycle |
| busy_o | output | 1 | A transaction is in progress |

## Verification
The bench builds the block with its defaults: 32-bit lines, sixteen 64-bit words and a five-cycle access delay. The exact eight-cycle read window can therefore be counted beat by beat. The small depth brings both the lowest and highest word index within reach, as well as addresses that alias through the ignored offset bits and upper bits. Separate scenarios cover foreign traffic injected during a read's access wait, an address cycle placed between two write beats, idle gaps between write beats, and a read issued in the very cycle the previous one frees the target.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_ADDR = 2'b01,
        PH_DATA = 2'b10
    } phase_e;

    typedef enum logic {
        CMD_READ  = 1'b0,
        CMD_WRITE = 1'b1
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_BEAT_LO,
        ST_BEAT_HI,
        ST_WR_LO,
        ST_WR_HI
    } seq_state_e;

    // Offset of the word index inside a byte address for 64-bit words.
    localparam int WORD_OFS_BITS = 3;

    function automatic logic is_phase(input logic [1:0] raw, input phase_e want);
        return phase_e'(raw) == want;
    endfunction

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 4,
    parameter int ACCESS_LAT = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            phase_i,
    input  logic                  cmd_i,
    input  logic [DATA_W-1:0]     lines_i,
    output logic                  busy_o,
    output logic                  drive_o,
    output logic                  hi_beat_o,
    output logic [IDX_W-1:0]      idx_o,
    output logic                  wr_en_o,
    output logic [2*DATA_W-1:0]   wr_word_o
);
    localparam int CNT_W = (ACCESS_LAT > 1) ? $clog2(ACCESS_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACCESS_LAT - 1);

    seq_state_e          state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [IDX_W-1:0]    idx_q;
    logic [DATA_W-1:0]   lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            lo_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (is_phase(phase_i, PH_ADDR)) begin
                        idx_q <= lines_i[WORD_OFS_BITS +: IDX_W];
                        cnt_q <= '0;
                        state_q <= (cmd_e'(cmd_i) == CMD_WRITE) ? ST_WR_LO : ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (cnt_q == CNT_LAST) state_q <= ST_BEAT_LO;
                    else                   cnt_q   <= cnt_q + 1'b1;
                end
                ST_BEAT_LO: state_q <= ST_BEAT_HI;
                ST_BEAT_HI: state_q <= ST_IDLE;
                ST_WR_LO: begin
                    if (is_phase(phase_i, PH_DATA)) begin
                        lo_q    <= lines_i;
                        state_q <= ST_WR_HI;
                    end
                end
                ST_WR_HI: begin
                    if (is_phase(phase_i, PH_DATA)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        drive_o   = (state_q == ST_BEAT_LO) || (state_q == ST_BEAT_HI);
        hi_beat_o = (state_q == ST_BEAT_HI);
        idx_o     = idx_q;
        wr_en_o   = (state_q == ST_WR_HI) && is_phase(phase_i, PH_DATA);
        wr_word_o = {lines_i, lo_q};
    end

endmodule

// File: rtl/mbus_word_store.sv
module mbus_word_store #(
    parameter int WORD_W = 64,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[idx] <= wr_word;
        end
    end

    assign rd_word = mem_q[idx];

endmodule

// File: rtl/mbus_mem_target.sv
module mbus_mem_target
    import mbus_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int WORDS      = 16,
    parameter int ACCESS_LAT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_phase_i,
    input  logic              bus_cmd_i,
    input  logic [DATA_W-1:0] bus_lines_i,
    output logic [DATA_W-1:0] bus_lines_o,
    output logic              drive_en_o,
    output logic              busy_o
);
    localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int WORD_W = 2 * DATA_W;

    logic              hi_beat;
    logic              drive;
    logic              wr_en;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] rd_word;

    mbus_seq #(
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W),
        .ACCESS_LAT(ACCESS_LAT)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .phase_i  (bus_phase_i),
        .cmd_i    (bus_cmd_i),
        .lines_i  (bus_lines_i),
        .busy_o   (busy_o),
        .drive_o  (drive),
        .hi_beat_o(hi_beat),
        .idx_o    (idx),
        .wr_en_o  (wr_en),
        .wr_word_o(wr_word)
    );

    mbus_word_store #(
        .WORD_W(WORD_W),
        .DEPTH (WORDS),
        .IDX_W (IDX_W)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .idx    (idx),
        .wr_word(wr_word),
        .rd_word(rd_word)
    );

    always_comb begin
        drive_en_o = drive;
        if (!drive)       bus_lines_o = '0;
        else if (hi_beat) bus_lines_o = rd_word[WORD_W-1:DATA_W];
        else              bus_lines_o = rd_word[DATA_W-1:0];
    end

endmodule

// File: rtl/mbus_mem_target_chk.sv
module mbus_mem_target_chk #(
    parameter int DATA_W     = 32,
    parameter int ACCESS_LAT = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        bus_phase_i,
    input logic              bus_cmd_i,
    input logic [DATA_W-1:0] bus_lines_o,
    input logic              drive_en_o,
    input logic              busy_o
);
    logic accept;
    int   since_q;
    logic rd_pend_q;
    logic wr_act_q;

    assign accept = !busy_o && (bus_phase_i == 2'b01);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q   <= 0;
            rd_pend_q <= 1'b0;
            wr_act_q  <= 1'b0;
        end else if (accept) begin
            since_q   <= 1;
            rd_pend_q <= !bus_cmd_i;
            wr_act_q  <= bus_cmd_i;
        end else begin
            if (busy_o) since_q <= since_q + 1;
            else        wr_act_q <= 1'b0;
        end
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy_o);

    // R3
    beat_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_en_o) |-> (rd_pend_q && since_q == ACCESS_LAT + 1));

    // R3
    second_beat_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_en_o) |=> drive_en_o);

    // R3
    beat_end_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_en_o && $past(drive_en_o)) |=> !drive_en_o);

    // R5
    quiet_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !drive_en_o |-> (bus_lines_o == '0));

    // R5
    drive_owner_chk: assert property (@(posedge clk) disable iff (rst)
        drive_en_o |-> busy_o);

    // R6
    write_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_act_q && busy_o) |-> !drive_en_o);

endmodule

bind mbus_mem_target mbus_mem_target_chk #(
    .DATA_W    (DATA_W),
    .ACCESS_LAT(ACCESS_LAT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_phase_i(bus_phase_i),
    .bus_cmd_i  (bus_cmd_i),
    .bus_lines_o(bus_lines_o),
    .drive_en_o (drive_en_o),
    .busy_o     (busy_o)
);

// File: tb/tb_mbus_mem_target.sv
module tb_mbus_mem_target;
    localparam int DATA_W = 32;
    localparam int WORDS  = 16;
    localparam int LAT    = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        phase = 2'b00;
    logic              cmd = 1'b0;
    logic [DATA_W-1:0] lines_in = '0;
    logic [DATA_W-1:0] lines_out;
    logic              drive_en;
    logic              busy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mbus_mem_target #(.DATA_W(DATA_W), .WORDS(WORDS), .ACCESS_LAT(LAT)) dut (
        .clk(clk), .rst(rst), .bus_phase_i(phase), .bus_cmd_i(cmd),
        .bus_lines_i(lines_in), .bus_lines_o(lines_out),
        .drive_en_o(drive_en), .busy_o(busy)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_bus(input logic [1:0] ph, input logic c, input logic [31:0] v);
        phase = ph; cmd = c; lines_in = v;
    endtask

    // Read with optional foreign traffic during the access wait (R8).
    task automatic do_read(input logic [31:0] addr, input logic [63:0] exp, input string req, input bit intrude);
        drive_bus(2'b01, 1'b0, addr);
        @(negedge clk);
        drive_bus(2'b00, 1'b0, 32'h0);
        for (int k = 1; k <= LAT; k++) begin
            chk(busy === 1'b1, "R2 busy during access", 64'(busy), 64'd1);
            chk(drive_en === 1'b0 && lines_out === '0, "R5 silent during access", 64'(drive_en), 64'd0);
            if (intrude) begin
                if (k == 2)      drive_bus(2'b01, 1'b1, 32'h0000_0020);
                else if (k == 3) drive_bus(2'b10, 1'b0, 32'hDEAD_0001);
                else if (k == 4) drive_bus(2'b10, 1'b0, 32'hDEAD_0002);
                else             drive_bus(2'b00, 1'b0, 32'h0);
            end
            @(negedge clk);
        end
        drive_bus(2'b00, 1'b0, 32'h0);
        chk(drive_en === 1'b1, {req, " R3 first beat cycle"}, 64'(drive_en), 64'd1);
        chk(lines_out === exp[31:0], {req, " R4 low beat"}, 64'(lines_out), 64'(exp[31:0]));
        @(negedge clk);
        chk(drive_en === 1'b1, {req, " R3 second beat cycle"}, 64'(drive_en), 64'd1);
        chk(lines_out === exp[63:32], {req, " R4 high beat"}, 64'(lines_out), 64'(exp[63:32]));
        @(negedge clk);
        chk(drive_en === 1'b0 && busy === 1'b0, {req, " R3 done at cycle 8"}, {62'd0, drive_en, busy}, 64'd0);
        chk(lines_out === '0, {req, " R5 lines released"}, 64'(lines_out), 64'd0);
    endtask

    // Write with a number of gap cycles of a chosen phase between beats (R7, R8).
    task automatic do_write(input logic [31:0] addr, input logic [63:0] data, input int gaps, input logic [1:0] gap_ph);
        drive_bus(2'b01, 1'b1, addr);
        @(negedge clk);
        chk(busy === 1'b1, "R2 busy after write address", 64'(busy), 64'd1);
        drive_bus(2'b10, 1'b0, data[31:0]);
        @(negedge clk);
        for (int g = 0; g < gaps; g++) begin
            drive_bus(gap_ph, 1'b0, 32'hBAD0_0000 | 32'(g));
            chk(drive_en === 1'b0, "R6 no drive during write", 64'(drive_en), 64'd0);
            @(negedge clk);
        end
        chk(busy === 1'b1, "R7 waits for second beat", 64'(busy), 64'd1);
        drive_bus(2'b10, 1'b0, data[63:32]);
        @(negedge clk);
        drive_bus(2'b00, 1'b0, 32'h0);
        chk(busy === 1'b0 && drive_en === 1'b0, "R6 write complete", {62'd0, busy, drive_en}, 64'd0);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired (R3 progress)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(busy === 1'b0 && drive_en === 1'b0, "R1 reset flags", {62'd0, busy, drive_en}, 64'd0);
        chk(lines_out === '0, "R1 reset lines", 64'(lines_out), 64'd0);
        do_read(32'h0000_0000, 64'd0, "R1 word0 zero", 1'b0);
        do_read(32'h0000_0078, 64'd0, "R1 word15 zero", 1'b0);

        // R6 plain write, R3/R4 read back
        do_write(32'h0000_0010, 64'h1122_3344_5566_7788, 0, 2'b00);
        do_read(32'h0000_0010, 64'h1122_3344_5566_7788, "R6 readback", 1'b0);
        // R9 aliasing through offset and upper bits (back-to-back reads)
        do_read(32'h0000_0014, 64'h1122_3344_5566_7788, "R9 offset bits", 1'b0);
        do_read(32'hF000_0097, 64'h1122_3344_5566_7788, "R9 upper bits", 1'b0);

        // R7 idle gaps between write beats, top index
        do_write(32'h0000_0078, 64'hCAFE_F00D_0BAD_BEEF, 2, 2'b00);
        do_read(32'h0000_0078, 64'hCAFE_F00D_0BAD_BEEF, "R7 gapped write", 1'b0);
        do_read(32'h0000_0010, 64'h1122_3344_5566_7788, "R9 neighbour intact", 1'b0);

        // R8 foreign traffic during a read
        do_write(32'h0000_0008, 64'hA5A5_0001_5A5A_0002, 0, 2'b00);
        do_read(32'h0000_0008, 64'hA5A5_0001_5A5A_0002, "R8 read under traffic", 1'b1);
        do_read(32'h0000_0020, 64'd0, "R8 intruding write dropped", 1'b0);

        // R8 address cycle between write beats is ignored
        do_write(32'h0000_0030, 64'h0F0F_1234_F0F0_5678, 1, 2'b01);
        do_read(32'h0000_0030, 64'h0F0F_1234_F0F0_5678, "R8 addr between beats", 1'b0);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule